// File: doc/BRIEF.md
# SDRAM Clock and Power-Mode Controller

This block holds one 32-bit control word for an SDRAM memory subsystem and turns it into the low-level power signals that a command engine and clock buffer need. These signals are a registered enable for the external memory clock gate, one clock-enable (CKE) line per device, a request that carries an initialization command code, a self-refresh entry request, and a deep power-down request. Software reads the word back through the same register bus, and it learns the actual self-refresh mode from a separate acknowledge output.

Self-refresh is a handshake. Setting the request bit makes the controller wait until no transaction is pending. It then asks the command engine for a self-refresh command, drops every CKE, and only after that reports the acknowledge. Clearing the bit raises CKE first, and the acknowledge is withdrawn once the engine reports ready. Both command requests are valid/ready streams toward the engine, with `eng_ready` as the shared ready. A request holds its valid level and its code until it sees ready high at a clock edge. The two requests are never valid in the same cycle.

Control-word layout (read/write at address `CTRL_ADDR`, default 0x20): bit 0 = CKE hold, bit 1 = free-running clock, bit 2 = self-refresh request, bit 5 = memory clock off, bits 8:7 = init code (00 normal, 01 mode-register set, 10 precharge all, 11 no-op), bit 13 = deep power-down. All other bits are reserved.

Top module: `sdram_pwr_ctrl`

## Requirements
- R1: While reset is held and right after it, the word reads 0x00000004 at `CTRL_ADDR` (only the self-refresh request bit set), and `init_valid`, `sr_cmd_valid`, `sr_ack` and `clk_gate_en` are 0.
- R2: A write to `CTRL_ADDR` stores only bits 13, 8:7, 5, 2, 1 and 0. Reserved bits read 0. A read at any other address returns 0.
- R3: An accepted write whose new or old init code is nonzero raises `init_valid` on the next cycle, with `init_code` equal to the written code. Both hold until `eng_ready` is seen high at an edge, and `init_valid` is low in the following cycle.
- R4: While `init_valid` or `sr_cmd_valid` is high, a write leaves the init field unchanged and raises no new request, while the other bits update.
- R5: With the request bit set, `sr_cmd_valid` rises only after an edge at which `xact_pend` is low and no init request is valid or being issued. It then stays high until `eng_ready` is seen.
- R6: In the cycle after the self-refresh handshake, all CKE lines are low. `sr_ack` rises one cycle later, with CKE still low.
- R7: Clearing the request bit while `sr_ack` is high drives all CKE high on the next cycle while `sr_ack` stays 1. `sr_ack` falls in the cycle after an edge that sees `eng_ready` high.
- R8: Outside self-refresh, CKE hold = 1 drives every CKE high. With CKE hold = 0, `cke[i]` is the inverse of `dev_idle[i]`.
- R9: `clk_gate_en` is registered and is 0 whenever the effective clock-off state is set. With the free-running bit = 1 it is otherwise 1. With that bit = 0 it is 0 when all devices are idle with nothing pending, or while CKE is held low for self-refresh.
- R10: A change of the clock-off bit reaches the effective state only at an edge where `xact_pend` is low.
- R11: `dpd_req` follows the deep power-down bit.
- R12: Clearing the request bit while entry still waits on a pending transaction returns to normal with no `sr_cmd_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| dev_idle | input | NUM_DEV | Per-device idle flags |
| xact_pend | input | 1 | An SDRAM transaction is pending |
| eng_ready | input | 1 | Command engine ready for both request streams |
| init_valid | output | 1 | Init command request valid |
| init_code | output | 2 | Init command code |
| sr_cmd_valid | output | 1 | Self-refresh entry command request valid |
| sr_ack | output | 1 | Self-refresh mode acknowledge |
| dpd_req | output | 1 | Deep power-down request |
| cke | output | NUM_DEV | Per-device clock enables |
| clk_gate_en | output | 1 | Registered enable for the memory clock gate |

## Verification
An init-code write and a self-refresh entry can collide in one cycle. They compete for the single `eng_ready`. The bench provokes this by setting the request bit and a nonzero init code in the same write, with the transaction pending flag dropped, and then by writing a new init code while the first request still waits for ready. The behavioural reference model decides each cycle which request may be valid and whether the later init write must be ignored. On every clock the bench compares its result with `init_valid`, `sr_cmd_valid`, `init_code` and the read-back word.

// File: rtl/sdpm_pkg.sv
package sdpm_pkg;

  localparam int WORD_W    = 32;
  localparam int B_CKEHOLD = 0;
  localparam int B_FREE    = 1;
  localparam int B_SRREQ   = 2;
  localparam int B_CLKOFF  = 5;
  localparam int B_INIT    = 7;
  localparam int B_DPD     = 13;

  localparam logic [WORD_W-1:0] WR_MASK =
      (WORD_W'(1) << B_CKEHOLD) | (WORD_W'(1) << B_FREE) |
      (WORD_W'(1) << B_SRREQ)   | (WORD_W'(1) << B_CLKOFF) |
      (WORD_W'(3) << B_INIT)    | (WORD_W'(1) << B_DPD);

  typedef struct packed {
    logic       dpd;
    logic [1:0] init;
    logic       clk_off;
    logic       sr_req;
    logic       clk_free;
    logic       cke_hold;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{dpd: 1'b0, init: 2'b00, clk_off: 1'b0,
                                 sr_req: 1'b1, clk_free: 1'b0, cke_hold: 1'b0};

  typedef enum logic [2:0] {
    SR_RUN, SR_WAIT, SR_CMD, SR_LOW, SR_IN, SR_EXIT
  } sr_state_e;

  function automatic logic [WORD_W-1:0] ctrl_pack(input ctrl_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[B_CKEHOLD]      = c.cke_hold;
    w[B_FREE]         = c.clk_free;
    w[B_SRREQ]        = c.sr_req;
    w[B_CLKOFF]       = c.clk_off;
    w[B_INIT+1:B_INIT] = c.init;
    w[B_DPD]          = c.dpd;
    return w;
  endfunction

endpackage

// File: rtl/sdpm_regfile.sv
module sdpm_regfile
  import sdpm_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              eng_ready,
  input  logic              sr_busy,
  output ctrl_t             ctrl,
  output logic              init_valid,
  output logic [1:0]        init_code,
  output logic              init_busy
);

  ctrl_t      ctrl_q, ctrl_d;
  logic       valid_q;
  logic [1:0] code_q;
  logic       hit, cmd_busy, issue;
  logic [1:0] wr_init;
  logic       unused_wdata;

  assign hit      = bus_wr && (bus_addr == CTRL_ADDR);
  assign cmd_busy = valid_q || sr_busy;
  assign wr_init  = bus_wdata[B_INIT+1:B_INIT];
  assign issue    = hit && !cmd_busy && ((wr_init != 2'b00) || (ctrl_q.init != 2'b00));
  assign unused_wdata = ^(bus_wdata & ~WR_MASK);

  always_comb begin
    ctrl_d = ctrl_q;
    if (hit) begin
      ctrl_d.cke_hold = bus_wdata[B_CKEHOLD];
      ctrl_d.clk_free = bus_wdata[B_FREE];
      ctrl_d.sr_req   = bus_wdata[B_SRREQ];
      ctrl_d.clk_off  = bus_wdata[B_CLKOFF];
      ctrl_d.dpd      = bus_wdata[B_DPD];
      if (!cmd_busy) ctrl_d.init = wr_init;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      valid_q <= 1'b0;
      code_q  <= 2'b00;
    end else begin
      ctrl_q <= ctrl_d;
      if (valid_q && eng_ready) begin
        valid_q <= 1'b0;
      end else if (issue) begin
        valid_q <= 1'b1;
        code_q  <= wr_init;
      end
    end
  end

  assign bus_rdata  = (bus_addr == CTRL_ADDR) ? ctrl_pack(ctrl_q) : '0;
  assign ctrl       = ctrl_q;
  assign init_valid = valid_q;
  assign init_code  = code_q;
  assign init_busy  = valid_q || issue;

endmodule

// File: rtl/sdpm_sr_fsm.sv
module sdpm_sr_fsm
  import sdpm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sr_req,
  input  logic xact_pend,
  input  logic init_busy,
  input  logic eng_ready,
  output logic sr_cmd_valid,
  output logic sr_ack,
  output logic cke_force_low,
  output logic cke_force_high
);

  sr_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SR_RUN:  if (sr_req) st_d = SR_WAIT;
      SR_WAIT: begin
        if (!sr_req)                       st_d = SR_RUN;
        else if (!xact_pend && !init_busy) st_d = SR_CMD;
      end
      SR_CMD:  if (eng_ready) st_d = SR_LOW;
      SR_LOW:  st_d = SR_IN;
      SR_IN:   if (!sr_req) st_d = SR_EXIT;
      SR_EXIT: if (eng_ready) st_d = SR_RUN;
      default: st_d = SR_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= SR_RUN;
    else        st_q <= st_d;
  end

  assign sr_cmd_valid   = (st_q == SR_CMD);
  assign sr_ack         = (st_q == SR_IN) || (st_q == SR_EXIT);
  assign cke_force_low  = (st_q == SR_LOW) || (st_q == SR_IN);
  assign cke_force_high = (st_q == SR_EXIT);

endmodule

// File: rtl/sdpm_clk_cke.sv
module sdpm_clk_cke #(
  parameter int NUM_DEV = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cke_hold,
  input  logic               clk_free,
  input  logic               clk_off,
  input  logic [NUM_DEV-1:0] dev_idle,
  input  logic               xact_pend,
  input  logic               cke_force_low,
  input  logic               cke_force_high,
  output logic [NUM_DEV-1:0] cke,
  output logic               clk_gate_en
);

  logic off_eff_q;
  logic gate_q;
  logic all_idle;
  logic idle_stop;
  logic want_run;

  assign all_idle  = &dev_idle;
  assign idle_stop = (all_idle && !xact_pend) || cke_force_low;
  assign want_run  = !off_eff_q && (clk_free || !idle_stop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_eff_q <= 1'b0;
      gate_q    <= 1'b0;
    end else begin
      if (!xact_pend) off_eff_q <= clk_off;
      gate_q <= want_run;
    end
  end

  assign clk_gate_en = gate_q;

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_cke
    always_comb begin
      if (cke_force_low)       cke[i] = 1'b0;
      else if (cke_force_high) cke[i] = 1'b1;
      else                     cke[i] = cke_hold || !dev_idle[i];
    end
  end

endmodule

// File: rtl/sdram_pwr_ctrl.sv
module sdram_pwr_ctrl
  import sdpm_pkg::*;
#(
  parameter int                NUM_DEV   = 2,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_DEV-1:0] dev_idle,
  input  logic               xact_pend,
  input  logic               eng_ready,
  output logic               init_valid,
  output logic [1:0]         init_code,
  output logic               sr_cmd_valid,
  output logic               sr_ack,
  output logic               dpd_req,
  output logic [NUM_DEV-1:0] cke,
  output logic               clk_gate_en
);

  ctrl_t ctrl;
  logic  init_busy;
  logic  force_low, force_high;

  sdpm_regfile #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .eng_ready  (eng_ready),
    .sr_busy    (sr_cmd_valid),
    .ctrl       (ctrl),
    .init_valid (init_valid),
    .init_code  (init_code),
    .init_busy  (init_busy)
  );

  sdpm_sr_fsm u_sr (
    .clk            (clk),
    .rst_n          (rst_n),
    .sr_req         (ctrl.sr_req),
    .xact_pend      (xact_pend),
    .init_busy      (init_busy),
    .eng_ready      (eng_ready),
    .sr_cmd_valid   (sr_cmd_valid),
    .sr_ack         (sr_ack),
    .cke_force_low  (force_low),
    .cke_force_high (force_high)
  );

  sdpm_clk_cke #(.NUM_DEV(NUM_DEV)) u_clk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cke_hold       (ctrl.cke_hold),
    .clk_free       (ctrl.clk_free),
    .clk_off        (ctrl.clk_off),
    .dev_idle       (dev_idle),
    .xact_pend      (xact_pend),
    .cke_force_low  (force_low),
    .cke_force_high (force_high),
    .cke            (cke),
    .clk_gate_en    (clk_gate_en)
  );

  assign dpd_req = ctrl.dpd;

endmodule

// File: rtl/sdram_pwr_ctrl_chk.sv
module sdram_pwr_ctrl_chk
  import sdpm_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int ADDR_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic [NUM_DEV-1:0] dev_idle,
  input logic               xact_pend,
  input logic               eng_ready,
  input logic               init_valid,
  input logic [1:0]         init_code,
  input logic               sr_cmd_valid,
  input logic               sr_ack,
  input logic               dpd_req,
  input logic [NUM_DEV-1:0] cke,
  input logic               clk_gate_en
);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~WR_MASK) == 32'h0);

  a_r3_init_hold: assert property (@(posedge clk) disable iff (!rst_n)
    init_valid && !eng_ready |=> init_valid && $stable(init_code));

  a_r5_sr_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sr_cmd_valid && !eng_ready |=> sr_cmd_valid);

  a_r5_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    !(sr_cmd_valid && init_valid));

  a_r6_ack_after_cke: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_ack) |-> (cke == '0) && ($past(cke) == '0));

  a_r7_cke_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_ack) |-> $past(&cke));

endmodule

bind sdram_pwr_ctrl sdram_pwr_ctrl_chk #(.NUM_DEV(NUM_DEV), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sdram_pwr_ctrl_bench.sv
module sdram_pwr_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ND = 2;
  localparam logic [7:0]  OFF  = 8'h20;
  localparam logic [31:0] MASK = 32'h0000_21A7;
  localparam int S_RUN = 0, S_WAIT = 1, S_CMD = 2, S_LOW = 3, S_IN = 4, S_EXIT = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_wr;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [ND-1:0] dev_idle, cke;
  logic xact_pend, eng_ready, init_valid, sr_cmd_valid, sr_ack, dpd_req, clk_gate_en;
  logic [1:0] init_code;

  sdram_pwr_ctrl u_sdram_pwr_ctrl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  string sc = "reset";

  logic [31:0] m_ctrl;
  logic m_iv, m_dis, m_gate;
  logic [1:0] m_code;
  int m_st;
  logic [ND-1:0] d_idle;
  logic d_pend, d_rdy;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%h expected=%h", tag, sc, act, exp);
    end
  endtask

  function automatic logic [ND-1:0] exp_cke();
    if (m_st == S_LOW || m_st == S_IN) return '0;
    if (m_st == S_EXIT) return '1;
    if (m_ctrl[0]) return '1;
    return ~dev_idle;
  endfunction

  task automatic compare();
    chk("R2 readback", bus_rdata, (bus_addr == OFF) ? m_ctrl : 32'h0);
    chk("R3 init_valid", 32'(init_valid), 32'(m_iv));
    if (m_iv) chk("R3 init_code", 32'(init_code), 32'(m_code));
    chk("R5 sr_cmd_valid", 32'(sr_cmd_valid), 32'(m_st == S_CMD));
    chk("R6 sr_ack", 32'(sr_ack), 32'(m_st == S_IN || m_st == S_EXIT));
    if (m_st == S_LOW || m_st == S_IN) chk("R6 cke low", 32'(cke), 32'(exp_cke()));
    else if (m_st == S_EXIT)           chk("R7 cke high", 32'(cke), 32'(exp_cke()));
    else                               chk("R8 cke policy", 32'(cke), 32'(exp_cke()));
    chk("R9 clk_gate_en", 32'(clk_gate_en), 32'(m_gate));
    chk("R11 dpd_req", 32'(dpd_req), 32'(m_ctrl[13]));
  endtask

  task automatic model_step();
    logic hit, busy, issue, insr, n_iv, n_dis, n_gate;
    logic [1:0] n_code;
    logic [31:0] n_ctrl;
    int n_st;
    hit   = bus_wr && (bus_addr == OFF);
    busy  = m_iv || (m_st == S_CMD);
    issue = hit && !busy && ((bus_wdata[8:7] != 2'b00) || (m_ctrl[8:7] != 2'b00));
    n_iv = m_iv; n_code = m_code; n_ctrl = m_ctrl; n_st = m_st;
    if (m_iv && eng_ready) n_iv = 1'b0;
    else if (issue) begin n_iv = 1'b1; n_code = bus_wdata[8:7]; end
    if (hit) begin
      n_ctrl = bus_wdata & MASK;
      if (busy) n_ctrl[8:7] = m_ctrl[8:7];
    end
    n_dis = xact_pend ? m_dis : m_ctrl[5];
    insr  = (m_st == S_LOW || m_st == S_IN);
    if (m_ctrl[1]) n_gate = !m_dis;
    else n_gate = !m_dis && !((&dev_idle) && !xact_pend) && !insr;
    case (m_st)
      S_RUN:  if (m_ctrl[2]) n_st = S_WAIT;
      S_WAIT: if (!m_ctrl[2]) n_st = S_RUN;
              else if (!xact_pend && !m_iv && !issue) n_st = S_CMD;
      S_CMD:  if (eng_ready) n_st = S_LOW;
      S_LOW:  n_st = S_IN;
      S_IN:   if (!m_ctrl[2]) n_st = S_EXIT;
      S_EXIT: if (eng_ready) n_st = S_RUN;
      default: n_st = S_RUN;
    endcase
    m_iv = n_iv; m_code = n_code; m_ctrl = n_ctrl; m_dis = n_dis; m_gate = n_gate; m_st = n_st;
  endtask

  task automatic cyc(input logic wr, input logic [7:0] addr, input logic [31:0] wd);
    bus_wr = wr; bus_addr = addr; bus_wdata = wd;
    dev_idle = d_idle; xact_pend = d_pend; eng_ready = d_rdy;
    #1;
    compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, OFF, 32'h0);
  endtask

  task automatic wrw(input logic [31:0] wd);
    cyc(1'b1, OFF, wd);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired [%s] actual=hung expected=done", sc);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = OFF; bus_wdata = '0;
    d_idle = '1; d_pend = 1'b1; d_rdy = 1'b0;
    dev_idle = d_idle; xact_pend = d_pend; eng_ready = d_rdy;
    m_ctrl = 32'h4; m_iv = 0; m_code = 0; m_dis = 0; m_gate = 0; m_st = S_RUN;
    repeat (3) @(posedge clk);
    @(negedge clk);
    sc = "R1 reset values";
    chk("R1 reset word", bus_rdata, 32'h0000_0004);
    chk("R1 init_valid", 32'(init_valid), 32'h0);
    chk("R1 sr_cmd_valid", 32'(sr_cmd_valid), 32'h0);
    chk("R1 sr_ack", 32'(sr_ack), 32'h0);
    chk("R1 clk_gate_en", 32'(clk_gate_en), 32'h0);
    bus_addr = 8'h24; #1;
    chk("R2 other address", bus_rdata, 32'h0);
    rst_n = 1'b1;

    sc = "R5 entry waits on pending";
    tick(4);
    d_pend = 0; tick(3);
    d_rdy = 1; tick(1); d_rdy = 0;
    sc = "R6 cke drop then ack";
    tick(3);

    sc = "R7 exit";
    wrw(32'h0000_0001); tick(2);
    d_rdy = 1; tick(1); d_rdy = 0; tick(2);

    sc = "R4 collision init vs self-refresh";
    wrw(32'h0000_0184); tick(2);
    wrw(32'h0000_0084); tick(2);
    d_rdy = 1; tick(3); d_rdy = 0; tick(2);
    sc = "R3 return to normal code";
    wrw(32'h0000_0000); tick(2);
    d_rdy = 1; tick(2); d_rdy = 0; tick(1);

    sc = "R8 R9 idle patterns";
    for (int p = 0; p < 8; p++) begin
      d_idle = 2'(p); d_pend = p[2]; tick(2);
    end
    wrw(32'h0000_0003); tick(3);
    wrw(32'h0000_0000);
    d_idle = '1; d_pend = 0; tick(3);

    sc = "R10 clock off deferred";
    d_idle = 2'b01; d_pend = 1; wrw(32'hFFFF_DE20); tick(3);
    d_pend = 0; tick(3);
    d_pend = 1; wrw(32'h0000_0000); tick(3);
    d_pend = 0; tick(3);

    sc = "R12 abort while waiting";
    d_pend = 1; wrw(32'h0000_0004); tick(3);
    wrw(32'h0000_0000); tick(2);
    d_pend = 0; tick(3);

    sc = "R11 deep power-down";
    wrw(32'h0000_2000); tick(2); wrw(32'h0000_0000); tick(1);

    sc = "R2 mixed random traffic";
    for (int i = 0; i < 3000; i++) begin
      d_idle = ND'($urandom); d_pend = ($urandom_range(0, 3) == 0); d_rdy = $urandom_range(0, 1);
      if ($urandom_range(0, 7) == 0) cyc(1'b1, ($urandom_range(0, 3) == 0) ? 8'h24 : OFF, $urandom);
      else cyc(1'b0, ($urandom_range(0, 1) == 0) ? 8'h28 : OFF, 32'h0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule